// File: doc/BRIEF.md
# Bank-Group Activate Spacing Tracker

This block keeps, for every bank of one or more DRAM ranks, the earliest cycle at which that bank may accept its next ACTIVATE. A scheduler reports each activate it issues with a one-cycle strobe carrying the rank, the bank and the cycle stamp of the command. The block then raises the deadline of every bank in that rank. A bank in the same bank group as the activated one gets the long spacing. Any other bank in the rank gets the short spacing.

Each bank drives an "activate permitted" flag that the scheduler can test directly. For the bank just activated, the block also returns two values one cycle after the strobe: the earliest precharge cycle and the earliest column-command cycle. All counts are in controller clock cycles, measured against a free-running cycle counter that the block exposes. The scheduler uses that counter to stamp its commands.

Top module: `bg_act_tracker`

## Requirements
- R1: While reset is asserted, `cycle_now`, `pre_at` and `col_at` read zero and every bit of `act_ok` reads one.
- R2: `cycle_now` advances by exactly one on every clock edge after reset is released.
- R3: In group mode, the group of a bank is its bank index modulo `GROUPS`. With 8 banks and 4 groups, banks 2 and 6 share a group, and banks 1, 3, 5 and 7 do not share it. Bit `rank*BANKS + bank` of `act_ok` belongs to that bank.
- R4: In group mode, an activate with stamp S raises the deadline of every bank in the same rank and group, including the activated bank, to at least S + `T_RRD_L`.
- R5: An activate with stamp S raises the deadline of every bank in the same rank but a different group to at least S + `T_RRD_S`.
- R6: An activate leaves the deadlines of banks in every other rank unchanged.
- R7: Deadlines are updated as the maximum of the stored value and the new bound, so an activate with an earlier stamp never lowers a deadline.
- R8: One cycle after an activate with stamp S, `pre_at` equals S + `T_RAS`. It holds that value until the next activate.
- R9: One cycle after an activate, `col_at` equals the larger of two values: that bank's stored column deadline, and S + `T_RCD`. The stored column deadline takes this value.
- R10: With group mode off, every bank in the activated rank, including the activated bank, gets S + `T_RRD_S`. The long spacing is never applied.
- R11: `act_ok` for a bank is high exactly when `cycle_now` is greater than or equal to that bank's stored deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_vld | input | 1 | One-cycle strobe: an activate was issued |
| act_rank | input | RANK_W | Rank of the activate |
| act_bank | input | BANK_W | Bank index within the rank |
| act_stamp | input | CYC_W | Cycle stamp of the activate |
| cycle_now | output | CYC_W | Free-running cycle counter |
| act_ok | output | RANKS*BANKS | Per-bank activate-permitted flags, bit rank*BANKS+bank |
| pre_at | output | CYC_W | Earliest precharge cycle of the last activated bank |
| col_at | output | CYC_W | Earliest column-command cycle of the last activated bank |

## Verification
Suppose a deadline register holds a wrong value, for example because it took the short spacing instead of the long one, or because it was lowered by an earlier stamp. The bank's `act_ok` bit is then wrong during a window of cycles right after the activate. That window starts on the first sample after the strobe and ends by the cycle stamp plus the long spacing. The bench therefore compares every bank's flag on every cycle against a model. A wrong column deadline stays hidden until that same bank is activated again, and then shows on `col_at` one cycle later. Re-activating a bank with an earlier stamp exposes it.

// File: rtl/bgat_pkg.sv
package bgat_pkg;

  // Group index of a bank; with grouping disabled every bank is alone.
  function automatic int unsigned grp_of(input int unsigned bank,
                                         input int unsigned groups,
                                         input bit          grp_mode);
    if (grp_mode) return bank % groups;
    return bank;
  endfunction

  // Larger of two unsigned cycle values.
  function automatic logic [63:0] umax(input logic [63:0] a,
                                       input logic [63:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bgat_cycle_ctr.sv
module bgat_cycle_ctr #(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CYC_W-1:0] cnt
);

  logic [CYC_W-1:0] cnt_q;
  logic [CYC_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q + CYC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/bgat_grp_cls.sv
// Classifies every bank against the current activate: same rank,
// same group (long spacing) and activated bank itself.
module bgat_grp_cls
  import bgat_pkg::*;
#(
  parameter int RANKS      = 2,
  parameter int BANKS      = 8,
  parameter int GROUPS     = 4,
  parameter bit GROUP_MODE = 1'b1,
  parameter int RANK_W     = 1,
  parameter int BANK_W     = 3
) (
  input  logic                   act_vld,
  input  logic [RANK_W-1:0]      act_rank,
  input  logic [BANK_W-1:0]      act_bank,
  output logic [RANKS*BANKS-1:0] in_rank,
  output logic [RANKS*BANKS-1:0] long_sel,
  output logic [RANKS*BANKS-1:0] is_tgt
);

  int unsigned act_grp;

  always_comb begin
    act_grp = grp_of(int'(act_bank), GROUPS, GROUP_MODE);
  end

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam int          IDX  = r * BANKS + b;
      localparam int unsigned BGRP = grp_of(b, GROUPS, GROUP_MODE);
      always_comb begin
        in_rank[IDX]  = act_vld && (act_rank == RANK_W'(r));
        is_tgt[IDX]   = in_rank[IDX] && (act_bank == BANK_W'(b));
        long_sel[IDX] = GROUP_MODE && in_rank[IDX] && (act_grp == BGRP);
      end
    end
  end

endmodule

// File: rtl/bgat_bank_slot.sv
// One bank: activate deadline and column deadline, raised by max only.
module bgat_bank_slot #(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cnt,
  input  logic             raise_en,
  input  logic [CYC_W-1:0] raise_to,
  input  logic             col_en,
  input  logic [CYC_W-1:0] col_to,
  output logic             ok,
  output logic [CYC_W-1:0] col_dl
);

  logic [CYC_W-1:0] dl_q, dl_nx;
  logic [CYC_W-1:0] col_q, col_nx;

  always_comb begin
    dl_nx  = (raise_to > dl_q) ? raise_to : dl_q;
    col_nx = (col_to > col_q)  ? col_to   : col_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dl_q <= '0;
    else if (raise_en) dl_q <= dl_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_en) col_q <= col_nx;
  end

  assign ok     = (cnt >= dl_q);
  assign col_dl = col_q;

endmodule

// File: rtl/bg_act_tracker.sv
module bg_act_tracker
  import bgat_pkg::*;
#(
  parameter int RANKS      = 2,
  parameter int BANKS      = 8,
  parameter int GROUPS     = 4,
  parameter bit GROUP_MODE = 1'b1,
  parameter int CYC_W      = 32,
  parameter int T_RRD_S    = 4,
  parameter int T_RRD_L    = 6,
  parameter int T_RAS      = 28,
  parameter int T_RCD      = 14,
  localparam int RANK_W    = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W    = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int NB_TOT    = RANKS * BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_vld,
  input  logic [RANK_W-1:0] act_rank,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [CYC_W-1:0]  act_stamp,
  output logic [CYC_W-1:0]  cycle_now,
  output logic [NB_TOT-1:0] act_ok,
  output logic [CYC_W-1:0]  pre_at,
  output logic [CYC_W-1:0]  col_at
);

  localparam logic [CYC_W-1:0] D_SHORT = CYC_W'(T_RRD_S);
  localparam logic [CYC_W-1:0] D_LONG  = CYC_W'(T_RRD_L);
  localparam logic [CYC_W-1:0] D_RAS   = CYC_W'(T_RAS);
  localparam logic [CYC_W-1:0] D_RCD   = CYC_W'(T_RCD);

  // Configuration legality: groups must tile the banks evenly and the
  // same-group spacing must exceed the cross-group spacing.
  if (GROUP_MODE && (GROUPS < 1 || GROUPS > BANKS || (BANKS % GROUPS) != 0
                     || T_RRD_L <= T_RRD_S)) begin : g_cfg_bad
    $error("bg_act_tracker: illegal bank-group configuration");
  end

  logic [CYC_W-1:0]  cnt;
  logic [NB_TOT-1:0] in_rank, long_sel, is_tgt;
  logic [CYC_W-1:0]  bnd_short, bnd_long, bnd_col, bnd_pre;
  logic [CYC_W-1:0]  col_dl [NB_TOT];
  logic [CYC_W-1:0]  tgt_col;
  logic [CYC_W-1:0]  pre_q, pre_nx, colo_q, colo_nx;

  bgat_cycle_ctr #(.CYC_W(CYC_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt)
  );

  bgat_grp_cls #(
    .RANKS(RANKS), .BANKS(BANKS), .GROUPS(GROUPS),
    .GROUP_MODE(GROUP_MODE), .RANK_W(RANK_W), .BANK_W(BANK_W)
  ) u_cls (
    .act_vld  (act_vld),
    .act_rank (act_rank),
    .act_bank (act_bank),
    .in_rank  (in_rank),
    .long_sel (long_sel),
    .is_tgt   (is_tgt)
  );

  always_comb begin
    bnd_short = act_stamp + D_SHORT;
    bnd_long  = act_stamp + D_LONG;
    bnd_col   = act_stamp + D_RCD;
    bnd_pre   = act_stamp + D_RAS;
  end

  for (genvar i = 0; i < NB_TOT; i++) begin : g_slot
    bgat_bank_slot #(.CYC_W(CYC_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .raise_en (in_rank[i]),
      .raise_to (long_sel[i] ? bnd_long : bnd_short),
      .col_en   (is_tgt[i]),
      .col_to   (bnd_col),
      .ok       (act_ok[i]),
      .col_dl   (col_dl[i])
    );
  end

  // Stored column deadline of the activated bank (zero if out of range).
  always_comb begin
    tgt_col = '0;
    for (int i = 0; i < NB_TOT; i++) begin
      if (is_tgt[i]) tgt_col = col_dl[i];
    end
  end

  always_comb begin
    pre_nx  = bnd_pre;
    colo_nx = CYC_W'(umax(64'(tgt_col), 64'(bnd_col)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      colo_q <= '0;
    end else if (act_vld) begin
      pre_q  <= pre_nx;
      colo_q <= colo_nx;
    end
  end

  assign cycle_now = cnt;
  assign pre_at    = pre_q;
  assign col_at    = colo_q;

endmodule

// File: rtl/bg_act_tracker_chk.sv
module bg_act_tracker_chk #(
  parameter int RANKS   = 2,
  parameter int BANKS   = 8,
  parameter int CYC_W   = 32,
  parameter int T_RRD_S = 4,
  parameter int T_RAS   = 28,
  parameter int T_RCD   = 14,
  parameter int RANK_W  = 1,
  parameter int BANK_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   act_vld,
  input logic [RANK_W-1:0]      act_rank,
  input logic [BANK_W-1:0]      act_bank,
  input logic [CYC_W-1:0]       act_stamp,
  input logic [CYC_W-1:0]       cycle_now,
  input logic [RANKS*BANKS-1:0] act_ok,
  input logic [CYC_W-1:0]       pre_at,
  input logic [CYC_W-1:0]       col_at
);

  int tgt;
  always_comb tgt = int'(act_rank) * BANKS + int'(act_bank);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cycle_now == $past(cycle_now) + CYC_W'(1));

  // R8
  pre_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |=> pre_at == $past(act_stamp) + CYC_W'(T_RAS));

  // R9
  col_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |=> col_at >= $past(act_stamp) + CYC_W'(T_RCD));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_vld |=> $stable(pre_at) && $stable(col_at));

  // R11
  if (T_RRD_S > 1) begin : g_self
    self_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_vld && act_stamp == cycle_now && int'(act_rank) < RANKS
        && int'(act_bank) < BANKS |=> !act_ok[$past(tgt)]);
  end

  for (genvar i = 0; i < RANKS * BANKS; i++) begin : g_keep
    // R6
    keep_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_vld || act_rank != RANK_W'(i / BANKS)) && act_ok[i] |=> act_ok[i]);
  end

endmodule

bind bg_act_tracker bg_act_tracker_chk #(
  .RANKS(RANKS), .BANKS(BANKS), .CYC_W(CYC_W), .T_RRD_S(T_RRD_S),
  .T_RAS(T_RAS), .T_RCD(T_RCD), .RANK_W(RANK_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_rank(act_rank),
  .act_bank(act_bank), .act_stamp(act_stamp), .cycle_now(cycle_now),
  .act_ok(act_ok), .pre_at(pre_at), .col_at(col_at)
);

// File: tb/bg_act_tracker_bench.sv
`timescale 1ns/1ps
module bg_act_tracker_bench;

  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        act_vld;
  logic [0:0]  act_rank;
  logic [2:0]  act_bank;
  logic [31:0] act_stamp;
  logic [31:0] now_g, pre_g, col_g, now_f, pre_f, col_f;
  logic [NB-1:0] ok_g, ok_f;

  int checks = 0;
  int errors = 0;

  logic [31:0] mdl_g [NB];
  logic [31:0] mdl_f [NB];
  logic [31:0] colm  [NB];
  string       tag_g [NB];

  always #2 clk = ~clk;

  bg_act_tracker u_bg_act_tracker (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_rank(act_rank),
    .act_bank(act_bank), .act_stamp(act_stamp), .cycle_now(now_g),
    .act_ok(ok_g), .pre_at(pre_g), .col_at(col_g));

  bg_act_tracker #(.GROUP_MODE(1'b0)) u_flat (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_rank(act_rank),
    .act_bank(act_bank), .act_stamp(act_stamp), .cycle_now(now_f),
    .act_ok(ok_f), .pre_at(pre_f), .col_at(col_f));

  // Vector: [15] rank, [14:12] bank, [11:6] signed stamp offset, [5:0] wait
  localparam logic [15:0] VEC [11] = '{
    {1'b0, 3'd0, 6'd0,  6'd8},   // fresh activate
    {1'b0, 3'd4, 6'd0,  6'd3},   // same group as bank 0
    {1'b0, 3'd1, 6'd0,  6'd2},   // other group
    {1'b1, 3'd3, 6'd0,  6'd7},   // other rank
    {1'b0, 3'd0, 6'd58, 6'd0},   // offset -6
    {1'b0, 3'd0, 6'd57, 6'd1},   // offset -7: column floor kept
    {1'b1, 3'd7, 6'd5,  6'd9},   // stamp ahead of counter
    {1'b0, 3'd2, 6'd0,  6'd2},
    {1'b0, 3'd6, 6'd62, 6'd6},   // offset -2
    {1'b1, 3'd3, 6'd0,  6'd0},
    {1'b0, 3'd5, 6'd3,  6'd10}
  };

  task automatic chk(input bit good, input string req,
                     input longint act, input longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NB; i++) begin
      mdl_g[i] = '0; mdl_f[i] = '0; colm[i] = '0; tag_g[i] = "R1";
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < NB; i++) begin
      chk(ok_g[i] == (now_g >= mdl_g[i]), tag_g[i], ok_g[i], now_g >= mdl_g[i]);
      chk(ok_f[i] == (now_f >= mdl_f[i]), "R10", ok_f[i], now_f >= mdl_f[i]);
    end
  endtask

  task automatic do_act(input int r, input int b, input int ofs, input int wt);
    logic [31:0] c, s, bnd;
    int t;
    c = now_g;
    s = c + 32'(ofs);
    t = r * 8 + b;
    act_vld = 1'b1; act_rank = 1'(r); act_bank = 3'(b); act_stamp = s;
    @(negedge clk);
    act_vld = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (i / 8 == r) begin
        // R3 group = bank % 4; R4 long spacing, R5 short spacing
        bnd = s + (((i % 8) % 4 == b % 4) ? 32'd6 : 32'd4);
        if (bnd > mdl_g[i]) begin
          mdl_g[i] = bnd;
          tag_g[i] = ((i % 8) % 4 == b % 4) ? "R4" : "R5";
        end else tag_g[i] = "R7";
        if (s + 32'd4 > mdl_f[i]) mdl_f[i] = s + 32'd4;
      end else tag_g[i] = "R6";
    end
    if (s + 32'd14 > colm[t]) colm[t] = s + 32'd14;
    chk(now_g == c + 32'd1, "R2", now_g, c + 32'd1);
    chk(pre_g == s + 32'd28, "R8", pre_g, s + 32'd28);
    chk(col_g == colm[t], "R9", col_g, colm[t]);
    chk(col_f == colm[t], "R9", col_f, colm[t]);
    check_all();
    for (int k = 0; k < wt; k++) begin
      @(negedge clk);
      chk(pre_g == s + 32'd28, "R8", pre_g, s + 32'd28);
      check_all();
    end
  endtask

  task automatic check_reset();
    chk(ok_g == '1, "R1", ok_g, 16'hFFFF);
    chk(ok_f == '1, "R1", ok_f, 16'hFFFF);
    chk(now_g == 0, "R1", now_g, 0);
    chk(pre_g == 0 && col_g == 0, "R1", pre_g | col_g, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; act_vld = 1'b0; act_rank = '0; act_bank = '0; act_stamp = '0;
    clear_model();
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    for (int v = 0; v < 11; v++) begin
      do_act(int'(VEC[v][15]), int'(VEC[v][14:12]),
             int'($signed(VEC[v][11:6])), int'(VEC[v][5:0]));
    end

    // Reset mid-run clears all state (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check_reset();
    clear_model();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R3: activate bank 2; three cycles later only banks 2 and 6 blocked
    do_act(0, 2, 0, 3);
    for (int b = 0; b < 8; b++) begin
      chk(ok_g[b] == (b % 4 != 2), "R3", ok_g[b], b % 4 != 2);
      chk(ok_f[b] == 1'b1, "R10", ok_f[b], 1);
    end
    chk(ok_g[15:8] == 8'hFF, "R6", ok_g[15:8], 8'hFF);

    // Back-to-back activates on consecutive cycles, then settle
    do_act(1, 0, 0, 0);
    do_act(1, 4, 0, 0);
    do_act(1, 1, 0, 8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule